// File: doc/BRIEF.md
# Watchdog Timer With Pre-Reset Interrupt

This block watches for a stalled program. While enabled, it counts system clocks. When the count crosses a software-chosen power-of-two boundary, a timeout occurs. The timeout can raise an interrupt flag, which gives the interrupt handler a chance to recover. It also starts a fixed grace interval of 512 clocks. If software has not restarted the watchdog by the end of that interval, the block emits a one-clock reset request to the system reset controller.

Software keeps the watchdog quiet by pulsing the restart strobe more often than the chosen timeout. The restart strobe zeroes the count and also abandons any grace interval already running. The interrupt flag is cleared separately, with a write-one-to-clear strobe. Dropping the enable stops all activity. The counter width, the two tap bases and the grace length are parameters. Their defaults give a 27-bit counter, taps between bit 17 and bit 26, and a 512-clock grace interval.

Top module: `wdt_guard`

## Requirements
- R1: After reset, `wd_flag` and `wd_reset` are low and the internal count is zero.
- R2: `tap_sel` picks the timeout tap bit. Codes 0..3 select bits TAP_LO..TAP_LO+3, and codes 4..7 select bits TAP_HI..TAP_HI+3 (with the defaults: 17, 18, 19, 20, 23, 24, 25, 26). Suppose the clock edge that samples `kick` is edge K, and the tap bit is t. The timeout then occurs on edge K+2^t, and its effects are visible right after that edge.
- R3: When `irq_mode` is 1, a timeout sets `wd_flag`. When `irq_mode` is 0, `wd_flag` stays low, but the grace interval and the reset still follow.
- R4: `wd_reset` goes high exactly RST_DLY clocks (512 by default) after the timeout edge, and stays high for exactly one clock.
- R5: On the edge that raises `wd_reset`, the flag clears and the count returns to zero. If the watchdog stays enabled, the next timeout falls 2^t clocks after that edge.
- R6: `kick` zeroes the count and cancels a running grace interval, so no reset follows. It does not change `wd_flag`.
- R7: A high `flag_clr` clears `wd_flag` on the next edge. If a timeout occurs on the same edge, the flag is set instead.
- R8: While `wd_en` is low, the count holds at zero and no grace interval runs. `wd_flag` and `wd_reset` are low one clock after the low `wd_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wd_en | input | 1 | Watchdog enable |
| irq_mode | input | 1 | 1: a timeout raises the interrupt flag |
| kick | input | 1 | Restart strobe; zeroes the count and cancels the grace interval |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| tap_sel | input | 3 | Timeout tap code |
| wd_flag | output | 1 | Watchdog interrupt flag |
| wd_reset | output | 1 | One-clock system reset request |

## Verification
The bench shrinks the counter so that every timeout fits in a short run. It keeps the split between the two tap groups. Timeouts are tried on codes from both groups, which tells a wrong tap base or code mapping apart from a wrong grace length. Three patterns separate the restart and clear paths: a run kicked repeatedly before expiry, a kick inside the grace interval followed by a flag clear, and a flag clear that coincides with a timeout. A silent-mode run, a run left enabled through a reset, and a disable during the grace interval show that the reset path does not depend on the flag, that the count restarts after a reset, and that the enable has priority.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  typedef enum logic {
    GR_IDLE = 1'b0,
    GR_WAIT = 1'b1
  } grace_e;

  // Tap bit for a select code: two groups of four adjacent bits.
  function automatic int unsigned tap_index(input logic [2:0] sel,
                                            input int unsigned lo,
                                            input int unsigned hi);
    int unsigned off;
    off = 32'(sel[1:0]);
    return sel[2] ? (hi + off) : (lo + off);
  endfunction

  // Width of the grace counter, never zero.
  function automatic int unsigned grace_width(input int unsigned dly);
    return (dly > 1) ? $clog2(dly) : 1;
  endfunction

endpackage

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
  import wdt_guard_pkg::*;
#(
  parameter int unsigned CNT_W  = 27,
  parameter int unsigned TAP_LO = 17,
  parameter int unsigned TAP_HI = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             clear,
  input  logic [2:0]       tap_sel,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tap_hit
);

  int unsigned      tap;
  logic [CNT_W-1:0] low_mask;

  always_comb begin
    tap      = tap_index(tap_sel, TAP_LO, TAP_HI);
    low_mask = (CNT_W'(1) << tap) - CNT_W'(1);
  end

  // The next increment sets the tap bit: all bits below it are ones.
  assign tap_hit = advance && ((cnt_q & low_mask) == low_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (advance) cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/wdt_grace_timer.sv
module wdt_grace_timer
  import wdt_guard_pkg::*;
#(
  parameter int unsigned RST_DLY = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic active,
  output logic expire
);

  localparam int unsigned DLY_W = grace_width(RST_DLY);
  localparam logic [DLY_W-1:0] LAST = DLY_W'(RST_DLY - 1);

  grace_e           state_q;
  logic [DLY_W-1:0] dly_q;

  assign active = (state_q == GR_WAIT);
  assign expire = active && (dly_q == LAST) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GR_IDLE;
      dly_q   <= '0;
    end else if (abort) begin
      state_q <= GR_IDLE;
      dly_q   <= '0;
    end else if (state_q == GR_WAIT) begin
      if (dly_q == LAST) begin
        state_q <= GR_IDLE;
        dly_q   <= '0;
      end else begin
        dly_q <= dly_q + DLY_W'(1);
      end
    end else if (start) begin
      state_q <= GR_WAIT;
      dly_q   <= '0;
    end
  end

endmodule

// File: rtl/wdt_irq_flag.sv
module wdt_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_q
);

  // Setting has priority over clearing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int unsigned CNT_W   = 27,
  parameter int unsigned TAP_LO  = 17,
  parameter int unsigned TAP_HI  = 23,
  parameter int unsigned RST_DLY = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wd_en,
  input  logic       irq_mode,
  input  logic       kick,
  input  logic       flag_clr,
  input  logic [2:0] tap_sel,
  output logic       wd_flag,
  output logic       wd_reset
);

  // Named internal events, also observed by the checker.
  logic             advance;
  logic             clear_cnt;
  logic             timeout_evt;
  logic             expire_evt;
  logic             grace_active;
  logic             grace_abort;
  logic [CNT_W-1:0] cnt_q;
  logic             wd_reset_q;

  assign advance     = wd_en && !kick && !grace_active;
  assign clear_cnt   = !wd_en || kick || expire_evt;
  assign grace_abort = !wd_en || kick;

  wdt_tick_counter #(
    .CNT_W (CNT_W),
    .TAP_LO(TAP_LO),
    .TAP_HI(TAP_HI)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(advance),
    .clear  (clear_cnt),
    .tap_sel(tap_sel),
    .cnt_q  (cnt_q),
    .tap_hit(timeout_evt)
  );

  wdt_grace_timer #(
    .RST_DLY(RST_DLY)
  ) u_grace (
    .clk   (clk),
    .rst_n (rst_n),
    .start (timeout_evt),
    .abort (grace_abort),
    .active(grace_active),
    .expire(expire_evt)
  );

  wdt_irq_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (timeout_evt && irq_mode),
    .clr   (flag_clr || expire_evt || !wd_en),
    .flag_q(wd_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_reset_q <= 1'b0;
    else        wd_reset_q <= expire_evt;
  end

  assign wd_reset = wd_reset_q;

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int unsigned CNT_W = 27
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wd_en,
  input logic             kick,
  input logic             flag_clr,
  input logic             wd_flag,
  input logic             wd_reset,
  input logic             timeout_evt,
  input logic [CNT_W-1:0] cnt_q
);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> (!wd_flag && !wd_reset && cnt_q == '0));

  // R4
  reset_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |=> !wd_reset);

  // R5
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |-> (!wd_flag && cnt_q == '0));

  // R6
  kick_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !wd_reset);

  // R6
  kick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && wd_en) |=> cnt_q == '0);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !timeout_evt) |=> !wd_flag);

  // R3
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag) |-> $past(timeout_evt));

endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wd_en      (wd_en),
  .kick       (kick),
  .flag_clr   (flag_clr),
  .wd_flag    (wd_flag),
  .wd_reset   (wd_reset),
  .timeout_evt(timeout_evt),
  .cnt_q      (cnt_q)
);

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;

  localparam int CNT_W   = 12;
  localparam int TAP_LO  = 2;
  localparam int TAP_HI  = 8;
  localparam int RST_DLY = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wd_en = 1'b0;
  logic       irq_mode = 1'b0;
  logic       kick = 1'b0;
  logic       flag_clr = 1'b0;
  logic [2:0] tap_sel = 3'd0;
  logic       wd_flag;
  logic       wd_reset;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    kind;   // 0: flag rise, 1: reset pulse
    int    stamp;
    string req;
  } ev_t;

  ev_t exp_q[$];

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  wdt_guard #(
    .CNT_W(CNT_W), .TAP_LO(TAP_LO), .TAP_HI(TAP_HI), .RST_DLY(RST_DLY)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .irq_mode(irq_mode),
    .kick(kick), .flag_clr(flag_clr), .tap_sel(tap_sel),
    .wd_flag(wd_flag), .wd_reset(wd_reset)
  );

  // Timeout length restated as a lookup of the tap codes.
  function automatic int period(input int sel);
    case (sel)
      0: return 4;     1: return 8;     2: return 16;    3: return 32;
      4: return 256;   5: return 512;   6: return 1024;  default: return 2048;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp_v, cyc);
    end
  endtask

  task automatic push(input int kind, input int stamp, input string req);
    ev_t e;
    e.kind = kind; e.stamp = stamp; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: pops expected events and compares kind and cycle.
  logic prev_flag = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wd_flag && !prev_flag) got(0);
      if (wd_reset) got(1);
    end
    prev_flag = wd_flag;
  end

  task automatic got(input int kind);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL unexpected event actual kind=%0d cycle=%0d expected=none", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.stamp != cyc) begin
        failures++;
        $display("FAIL %s actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                 e.req, kind, cyc, e.kind, e.stamp);
      end
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Starts a run: returns the edge number that samples the kick.
  task automatic start_run(input int sel, input logic mode, output int k);
    wd_en = 1'b1; irq_mode = mode; tap_sel = 3'(sel); kick = 1'b1;
    k = cyc + 1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic stop_run();
    wd_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic plain_timeout(input int sel, input string req);
    int k;
    start_run(sel, 1'b1, k);
    push(0, k + period(sel), req);
    push(1, k + period(sel) + RST_DLY, "R4");
    wait_until(k + period(sel) + RST_DLY);
    stop_run();
  endtask

  initial begin
    int k, k2;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 flag after reset", wd_flag, 1'b0);
    check("R1 reset after reset", wd_reset, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 flag idle", wd_flag, 1'b0);

    // R2: taps from both groups
    plain_timeout(0, "R2 sel0");
    plain_timeout(3, "R2 sel3");
    plain_timeout(4, "R2 sel4");
    plain_timeout(7, "R2 sel7");

    // R3: silent mode, reset only
    start_run(3, 1'b0, k);
    push(1, k + 32 + RST_DLY, "R3 silent reset");
    wait_until(k + 40);
    check("R3 flag silent", wd_flag, 1'b0);
    wait_until(k + 32 + RST_DLY);
    stop_run();

    // R5: stays enabled through a reset, count restarts
    start_run(0, 1'b1, k);
    push(0, k + 4, "R5 first");
    push(1, k + 4 + RST_DLY, "R4");
    push(0, k + 8 + RST_DLY, "R5 restart after reset");
    wait_until(k + 4 + RST_DLY);
    check("R5 flag cleared by reset", wd_flag, 1'b0);
    wait_until(k + 8 + RST_DLY);
    stop_run();

    // R6: periodic kicks keep it quiet
    start_run(4, 1'b1, k);
    for (int i = 0; i < 5; i++) begin
      wait_until(k + 200);
      kick = 1'b1; k = cyc + 1;
      @(negedge clk); kick = 1'b0;
    end
    check("R6 no flag with kicks", wd_flag, 1'b0);
    push(0, k + 256, "R6 after last kick");
    push(1, k + 256 + RST_DLY, "R4");
    wait_until(k + 256 + RST_DLY);
    stop_run();

    // R6 + R7: kick inside grace, then clear the flag
    start_run(0, 1'b1, k);
    push(0, k + 4, "R6 grace start");
    wait_until(k + 100);
    kick = 1'b1; k2 = cyc + 1;
    @(negedge clk); kick = 1'b0; flag_clr = 1'b1;
    check("R6 flag kept by kick", wd_flag, 1'b1);
    @(negedge clk); flag_clr = 1'b0;
    check("R7 flag cleared", wd_flag, 1'b0);
    push(0, k2 + 4, "R6 new period");
    push(1, k2 + 4 + RST_DLY, "R6 reset after kick");
    wait_until(k2 + 4 + RST_DLY);
    stop_run();

    // R7: clear on the timeout edge loses to the set
    start_run(0, 1'b1, k);
    push(0, k + 4, "R7 set wins");
    push(1, k + 4 + RST_DLY, "R4");
    wait_until(k + 3);
    flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check("R7 set beats clear", wd_flag, 1'b1);
    wait_until(k + 4 + RST_DLY);
    stop_run();

    // R8: disable during grace
    start_run(1, 1'b1, k);
    push(0, k + 8, "R8 before disable");
    wait_until(k + 50);
    wd_en = 1'b0;
    @(negedge clk);
    check("R8 flag off when disabled", wd_flag, 1'b0);
    wait_until(k + 8 + RST_DLY + 20);
    check("R8 no reset when disabled", wd_reset, 1'b0);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL pending events actual=%0d expected=0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule